// File: doc/BRIEF.md
# Cache Tag Store with Lookup Comparator

This block is the directory memory of a direct-mapped secondary cache. Each line of the directory keeps a tag and three status flags (valid, dirty, write-through). The cache controller presents an index on `addr` and the upper address bits on `tag_in`. In the same cycle the block returns a combinational `hit`, which is the tag comparison. In dedicated mode the stored valid flag also gates it. Tag and status reads are combinational as well. Tag writes and status writes are separate, and each happens on the rising clock edge.

A synchronous clear input, sampled low at a clock edge, drops the status flags of every line in one cycle. This invalidates the whole cache. Each output that would be a three-state pad in a board-level part is modelled here as a data bus plus a drive flag (`*_vld`). A low drive flag means the pad is released. The block has no data stream and therefore no back-pressure. Every pin is a plain level control that the controller holds for a whole clock cycle.

Top module: `tag_lookup_store`

## Requirements
- R1: With the block active, `tag_wr_n` low at a rising edge stores `tag_in` at `addr`. Tag reads through `tag_out` are combinational, and `tag_out_vld` is high only while the block is active, `rst_n` is high and `tag_oe_n` is low.
- R2: Status writes use their own enable `stat_wr_n`, with stat bit 0 = valid, bit 1 = dirty and bit 2 = write-through. A status write leaves the tags unchanged, and a tag write leaves the status unchanged.
- R3: With `mode_generic` high, `hit` is high exactly when `tag_in` equals the stored tag at `addr`, whatever the stored valid bit is.
- R4: With `mode_generic` low, `hit` is also forced low whenever the stored valid bit at `addr` is 0.
- R5: `rst_n` sampled low at a rising edge clears all status bits of every line. Stored tags are kept.
- R6: While `rst_n` is low, the block behaves as follows. The tag port is released. `hit` is driven low, with `hit_vld` high when the block is active. `stat_out` reads 0 when it is enabled. Tag and status writes are ignored.
- R7: The block is active only when `sel_a_n` is low and `sel_b` is high. When it is not active, all drive flags are low and writes are ignored.
- R8: During a write cycle the data being written appears on the corresponding enabled output: `tag_in` on `tag_out`, and `stat_in` on `stat_out`.
- R9: With `pwr_dn_n` low, all drive flags are low and no write takes effect.
- R10: The output enables are independent of each other. `hit_vld` is low while the tag port is driven (`tag_oe_n` low) or a tag write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and status clear on its rising edge |
| rst_n | input | 1 | Synchronous status clear, active low |
| pwr_dn_n | input | 1 | Power-down, active low |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| mode_generic | input | 1 | 1: status is user data; 0: valid gates hit |
| addr | input | ADDR_W | Line index |
| tag_wr_n | input | 1 | Tag write enable, active low |
| stat_wr_n | input | 1 | Status write enable, active low |
| tag_oe_n | input | 1 | Tag output enable, active low |
| stat_oe_n | input | 1 | Status output enable, active low |
| tag_in | input | TAG_W | Tag to write or to compare |
| stat_in | input | 3 | Status to write {wt, dirty, valid} |
| tag_out | output | TAG_W | Tag read data |
| tag_out_vld | output | 1 | Tag port driven |
| stat_out | output | 3 | Status read data |
| stat_out_vld | output | 1 | Status port driven |
| hit | output | 1 | Lookup result, active high |
| hit_vld | output | 1 | Hit pin driven |

## Verification
The lookup is exercised with four kinds of input pattern:
- an exact tag on a valid line;
- a tag one bit away from the stored one, which separates a true compare from a partial one;
- an exact tag on a line whose valid flag is clear, tried in both modes, which isolates the mode gating;
- the all-ones tag at the top index, which catches truncated address or tag paths.

Read-back after tag-only and status-only writes shows that the two fields are independent. Writes attempted while deselected, powered down or held in clear are followed by reads of the same line, so that a leaking write is caught.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic wthru;
    logic dirty;
    logic valid;
  } tstat_t;
endpackage

// File: rtl/tag_field_mem.sv
module tag_field_mem #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  wdata,
  output logic [TAG_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/status_flop_bank.sv
module status_flop_bank
  import tagstore_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  tstat_t            wdata,
  output tstat_t            rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  tstat_t line_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!clr_n)
        line_q[i] <= '0;
      else if (wr_en && addr == ADDR_W'(i))
        line_q[i] <= wdata;
    end
  end

  assign rdata = line_q[addr];
endmodule

// File: rtl/tag_match_unit.sv
module tag_match_unit #(
  parameter int TAG_W = 12
) (
  input  logic             enable,
  input  logic             gate_by_valid,
  input  logic             stored_valid,
  input  logic [TAG_W-1:0] probe,
  input  logic [TAG_W-1:0] stored,
  output logic             hit
);
  logic [TAG_W-1:0] bit_eq;

  for (genvar b = 0; b < TAG_W; b++) begin : g_bit
    assign bit_eq[b] = ~(probe[b] ^ stored[b]);
  end

  always_comb begin
    hit = enable && (&bit_eq);
    if (gate_by_valid && !stored_valid) hit = 1'b0;
  end
endmodule

// File: rtl/tag_lookup_store.sv
module tag_lookup_store
  import tagstore_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              mode_generic,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tag_wr_n,
  input  logic              stat_wr_n,
  input  logic              tag_oe_n,
  input  logic              stat_oe_n,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [2:0]        stat_in,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_out_vld,
  output logic [2:0]        stat_out,
  output logic              stat_out_vld,
  output logic              hit,
  output logic              hit_vld
);
  logic             active;
  logic             run;
  logic             tag_we;
  logic             stat_we;
  logic [TAG_W-1:0] tag_rd;
  tstat_t           stat_rd;
  tstat_t           stat_wd;
  logic             cmp_en;
  logic             cmp_hit;

  assign active  = !sel_a_n && sel_b && pwr_dn_n;
  assign run     = active && rst_n;
  assign tag_we  = run && !tag_wr_n;
  assign stat_we = run && !stat_wr_n;
  assign stat_wd = tstat_t'(stat_in);

  tag_field_mem #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
    .clk   (clk),
    .wr_en (tag_we),
    .addr  (addr),
    .wdata (tag_in),
    .rdata (tag_rd)
  );

  status_flop_bank #(.ADDR_W(ADDR_W)) u_flags (
    .clk   (clk),
    .clr_n (rst_n),
    .wr_en (stat_we),
    .addr  (addr),
    .wdata (stat_wd),
    .rdata (stat_rd)
  );

  assign cmp_en = run && tag_oe_n && tag_wr_n;

  tag_match_unit #(.TAG_W(TAG_W)) u_cmp (
    .enable        (cmp_en),
    .gate_by_valid (!mode_generic),
    .stored_valid  (stat_rd.valid),
    .probe         (tag_in),
    .stored        (tag_rd),
    .hit           (cmp_hit)
  );

  always_comb begin
    tag_out_vld = run && !tag_oe_n;
    tag_out     = '0;
    if (tag_out_vld) tag_out = tag_wr_n ? tag_rd : tag_in;

    stat_out_vld = active && !stat_oe_n;
    stat_out     = '0;
    if (stat_out_vld && rst_n) stat_out = stat_wr_n ? 3'(stat_rd) : stat_in;

    hit_vld = active && (!rst_n || (tag_oe_n && tag_wr_n));
    hit     = hit_vld && cmp_hit;
  end
endmodule

// File: rtl/tag_lookup_store_chk.sv
module tag_lookup_store_chk #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_dn_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              mode_generic,
  input logic [ADDR_W-1:0] addr,
  input logic              tag_wr_n,
  input logic              stat_wr_n,
  input logic              tag_oe_n,
  input logic              stat_oe_n,
  input logic [TAG_W-1:0]  tag_in,
  input logic [2:0]        stat_in,
  input logic [TAG_W-1:0]  tag_out,
  input logic              tag_out_vld,
  input logic [2:0]        stat_out,
  input logic              stat_out_vld,
  input logic              hit,
  input logic              hit_vld
);
  logic prev_rst_n;

  always_ff @(posedge clk) prev_rst_n <= rst_n;

  // R6: status clear holds the tag port released and the hit pin low
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      assert_clear_outputs_R6: assert (!tag_out_vld && !hit);
    end
  end

  // R5: the first status read after a clear returns zero
  always @(posedge clk) begin
    if (prev_rst_n === 1'b0 && rst_n === 1'b1 && stat_out_vld === 1'b1 && stat_wr_n === 1'b1) begin
      assert_cleared_flags_R5: assert (stat_out == 3'b000);
    end
  end

  assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n || !sel_b) |-> (!tag_out_vld && !stat_out_vld && !hit_vld));

  assert_powerdown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |-> (!tag_out_vld && !stat_out_vld && !hit_vld));

  assert_hit_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode_generic && stat_out_vld && stat_wr_n) |-> stat_out[0]);

  assert_hit_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_out_vld || !tag_wr_n) |-> !hit_vld);

  assert_tag_written_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n && sel_b && pwr_dn_n && !tag_wr_n) |=>
      (!(tag_out_vld && tag_wr_n && addr == $past(addr)) || tag_out == $past(tag_in)));
endmodule

bind tag_lookup_store tag_lookup_store_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/tag_lookup_store_bench.sv
`timescale 1ns/100ps
module tag_lookup_store_bench;
  localparam int AW = 6;
  localparam int TW = 12;
  localparam int NV = 17;

  // vector: [24] tag write, [23] status write, [22:17] addr, [16:5] tag,
  //         [4:2] status, [1] generic mode, [0] expected hit
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd5,  12'hABC, 3'b000, 1'b0, 1'b0},
    {1'b0, 1'b1, 6'd5,  12'h000, 3'b001, 1'b0, 1'b0},
    {1'b0, 1'b0, 6'd5,  12'hABC, 3'b000, 1'b0, 1'b1},
    {1'b0, 1'b0, 6'd5,  12'hABD, 3'b000, 1'b0, 1'b0},
    {1'b0, 1'b0, 6'd5,  12'hABC, 3'b000, 1'b1, 1'b1},
    {1'b1, 1'b0, 6'd9,  12'h123, 3'b000, 1'b0, 1'b0},
    {1'b0, 1'b0, 6'd9,  12'h123, 3'b000, 1'b0, 1'b0},
    {1'b0, 1'b0, 6'd9,  12'h123, 3'b000, 1'b1, 1'b1},
    {1'b0, 1'b1, 6'd9,  12'h000, 3'b110, 1'b0, 1'b0},
    {1'b0, 1'b0, 6'd9,  12'h123, 3'b000, 1'b0, 1'b0},
    {1'b0, 1'b1, 6'd9,  12'h000, 3'b111, 1'b0, 1'b0},
    {1'b0, 1'b0, 6'd9,  12'h123, 3'b000, 1'b0, 1'b1},
    {1'b0, 1'b0, 6'd5,  12'h123, 3'b000, 1'b1, 1'b0},
    {1'b1, 1'b0, 6'd63, 12'hFFF, 3'b000, 1'b0, 1'b0},
    {1'b0, 1'b1, 6'd63, 12'h000, 3'b001, 1'b0, 1'b0},
    {1'b0, 1'b0, 6'd63, 12'hFFF, 3'b000, 1'b0, 1'b1},
    {1'b0, 1'b0, 6'd63, 12'h7FF, 3'b000, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n, pwr_dn_n, sel_a_n, sel_b, mode_generic;
  logic [AW-1:0] addr;
  logic          tag_wr_n, stat_wr_n, tag_oe_n, stat_oe_n;
  logic [TW-1:0] tag_in;
  logic [2:0]    stat_in;
  logic [TW-1:0] tag_out;
  logic          tag_out_vld;
  logic [2:0]    stat_out;
  logic          stat_out_vld, hit, hit_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tag_lookup_store #(.ADDR_W(AW), .TAG_W(TW)) u_tag_lookup_store (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst_n = 1'b1; pwr_dn_n = 1'b1; sel_a_n = 1'b0; sel_b = 1'b1;
    mode_generic = 1'b0; tag_wr_n = 1'b1; stat_wr_n = 1'b1;
    tag_oe_n = 1'b1; stat_oe_n = 1'b1; tag_in = '0; stat_in = '0;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic read_tag(input logic [AW-1:0] a, input logic [TW-1:0] exp, input string req);
    addr = a; tag_oe_n = 1'b0;
    #1;
    check(req, {31'd0, tag_out_vld}, 32'd1);
    check(req, 32'(tag_out), 32'(exp));
    tag_oe_n = 1'b1;
  endtask

  task automatic read_stat(input logic [AW-1:0] a, input logic [2:0] exp, input string req);
    addr = a; stat_oe_n = 1'b0;
    #1;
    check(req, {31'd0, stat_out_vld}, 32'd1);
    check(req, 32'(stat_out), 32'(exp));
    stat_oe_n = 1'b1;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic gen,
                        input logic exp, input string req);
    addr = a; tag_in = t; mode_generic = gen;
    #1;
    check(req, {31'd0, hit_vld}, 32'd1);
    check(req, {31'd0, hit}, {31'd0, exp});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    addr = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    idle();

    // R5: the state after the clear
    read_stat(6'd5, 3'b000, "R5 reset state");

    // table walk: writes with pass-through, then lookups
    for (int i = 0; i < NV; i++) begin
      addr = VEC[i][22:17];
      if (VEC[i][24]) begin
        tag_wr_n = 1'b0; tag_oe_n = 1'b0; tag_in = VEC[i][16:5];
        #1;
        check("R8 tag pass-through", 32'(tag_out), 32'(VEC[i][16:5]));
        check("R1 tag port driven", {31'd0, tag_out_vld}, 32'd1);
      end else if (VEC[i][23]) begin
        stat_wr_n = 1'b0; stat_oe_n = 1'b0; stat_in = VEC[i][4:2];
        #1;
        check("R8 status pass-through", 32'(stat_out), 32'(VEC[i][4:2]));
      end else begin
        lookup(VEC[i][22:17], VEC[i][16:5], VEC[i][1], VEC[i][0],
               VEC[i][1] ? "R3 generic lookup" : "R4 dedicated lookup");
      end
      next_cycle();
    end

    // R1/R2: read back, then check that the two fields stay apart
    read_tag(6'd5, 12'hABC, "R1 tag readback");
    read_tag(6'd63, 12'hFFF, "R1 tag readback top index");
    read_stat(6'd9, 3'b111, "R2 status readback");
    addr = 6'd5; stat_wr_n = 1'b0; stat_in = 3'b011;
    next_cycle();
    read_tag(6'd5, 12'hABC, "R2 status write keeps tag");
    addr = 6'd9; tag_wr_n = 1'b0; tag_in = 12'h124;
    next_cycle();
    read_stat(6'd9, 3'b111, "R2 tag write keeps status");
    read_tag(6'd9, 12'h124, "R1 tag overwrite");

    // R10: output enables are independent; hit is released while the tag port is in use
    addr = 6'd5; tag_in = 12'hABC; tag_oe_n = 1'b0;
    #1;
    check("R10 hit released on tag read", {31'd0, hit_vld}, 32'd0);
    check("R10 status port idle", {31'd0, stat_out_vld}, 32'd0);
    tag_oe_n = 1'b1; tag_wr_n = 1'b0;
    #1;
    check("R10 hit released on tag write", {31'd0, hit_vld}, 32'd0);
    tag_wr_n = 1'b1; stat_oe_n = 1'b0;
    #1;
    check("R10 tag port idle", {31'd0, tag_out_vld}, 32'd0);
    check("R10 status port driven", {31'd0, stat_out_vld}, 32'd1);
    next_cycle();

    // R7: each select alone deselects the block
    sel_a_n = 1'b1; tag_oe_n = 1'b0; stat_oe_n = 1'b0;
    addr = 6'd5; tag_wr_n = 1'b0; tag_in = 12'h555;
    #1;
    check("R7 sel_a_n high quiet", {29'd0, tag_out_vld, stat_out_vld, hit_vld}, 32'd0);
    next_cycle();
    read_tag(6'd5, 12'hABC, "R7 write ignored when sel_a_n high");
    sel_b = 1'b0; tag_oe_n = 1'b0; stat_oe_n = 1'b0;
    stat_wr_n = 1'b0; stat_in = 3'b000;
    #1;
    check("R7 sel_b low quiet", {29'd0, tag_out_vld, stat_out_vld, hit_vld}, 32'd0);
    next_cycle();
    read_stat(6'd5, 3'b011, "R7 write ignored when sel_b low");

    // R9: power-down releases the outputs and blocks writes
    pwr_dn_n = 1'b0; tag_oe_n = 1'b0; stat_oe_n = 1'b0;
    addr = 6'd5; tag_wr_n = 1'b0; tag_in = 12'h666;
    stat_wr_n = 1'b0; stat_in = 3'b100;
    #1;
    check("R9 power-down quiet", {29'd0, tag_out_vld, stat_out_vld, hit_vld}, 32'd0);
    next_cycle();
    read_tag(6'd5, 12'hABC, "R9 tag write blocked");
    read_stat(6'd5, 3'b011, "R9 status write blocked");

    // R6: outputs while the clear is held, and a tag write during the clear
    rst_n = 1'b0; addr = 6'd5; tag_oe_n = 1'b0; stat_oe_n = 1'b0;
    #1;
    check("R6 tag port released", {31'd0, tag_out_vld}, 32'd0);
    check("R6 status reads zero", {28'd0, stat_out_vld, stat_out}, 32'h8);
    tag_oe_n = 1'b1; tag_in = 12'hABC;
    #1;
    check("R6 hit driven low", {30'd0, hit_vld, hit}, 32'h2);
    tag_wr_n = 1'b0; tag_in = 12'h777;
    next_cycle();

    // R5: every status flag is cleared and the tags are kept
    read_stat(6'd5, 3'b000, "R5 status cleared line 5");
    read_stat(6'd9, 3'b000, "R5 status cleared line 9");
    read_stat(6'd63, 3'b000, "R5 status cleared line 63");
    read_tag(6'd5, 12'hABC, "R6 write ignored during clear");
    lookup(6'd5, 12'hABC, 1'b0, 1'b0, "R4 invalid after clear");
    lookup(6'd5, 12'hABC, 1'b1, 1'b1, "R3 generic ignores cleared valid");
    next_cycle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule